// File: doc/BRIEF.md
# PMIC Power Key and Reset Trigger Sequencer

This block produces the pin sequences that ask a power-management chip to start up, to shut down, or to warm-reset the application processor. It owns two active-low outputs: a power-key line and a reset-in line. It watches three inputs: the power-good rail, the readback of the power-key line's pull-up, and the processor's reset indication.

A command is presented on a two-bit operation field together with a one-cycle start strobe. The block finishes every accepted command with a one-cycle done pulse. An error flag accompanies done when the sequence fails. A failed warm reset also raises a cold-reset request, so that the surrounding power controller can fall back to a full power cycle. All waiting is measured in pulses of a 1 ms tick input, which makes the windows independent of the core clock.

The power-on and power-off sequences use the same key output. Power-off also holds reset-in low. A warm reset uses reset-in alone and is confirmed by seeing the processor enter reset.

Top module: `pmic_trigger_seq`

## Requirements
- R1: Out of reset and whenever idle, `key_n` and `resin_n` are both high, and `done`, `err` and `cold_req` are low.
- R2: For an on command (`op` = 1) or an off command (`op` = 2), if `pgood` already equals the target (1 for on, 0 for off), the block pulses `done` with `err` low in the cycle after the strobe and never drives a pin.
- R3: If a command still needs action and `key_rb` is low when it is strobed, the block pulses `done` with `err` high and leaves both pins high.
- R4: On command: `key_n` goes low the cycle after the strobe while `resin_n` stays high. `pgood` is sampled only on cycles with `tick` high. On the first such cycle where `pgood` is high, `key_n` returns high and `done` pulses with `err` low.
- R5: Off command: `key_n` and `resin_n` both go low the cycle after the strobe. On the first tick where `pgood` is low, both return high and `done` pulses with `err` low.
- R6: If the target level is not seen by tick number WAIT_MS of a hold (default 350), both pins are released and `done` pulses with `err` high. `cold_req` stays low.
- R7: Warm-reset command (`op` = 3): `resin_n` is low for exactly PULSE_MS ticks (default 20) and `key_n` stays high. After that, `ap_rst` is sampled on each tick. If it is high on a tick within the next WAIT_MS ticks, `done` pulses with `err` low.
- R8: If `ap_rst` is not seen within that window, `done`, `err` and `cold_req` pulse together.
- R9: A strobe while a sequence runs has no effect on the pins or the outcome. A strobe with `op` = 0 is ignored.
- R10: `done` never stays high for two consecutive cycles, and `err` and `cold_req` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 1 ms |
| start | input | 1 | Command strobe |
| op | input | 2 | 1 on, 2 off, 3 warm reset, 0 none |
| pgood | input | 1 | Power-good rail level |
| key_rb | input | 1 | Readback of the power-key line pull-up |
| ap_rst | input | 1 | High while the processor is held in reset |
| key_n | output | 1 | Active-low power-key drive |
| resin_n | output | 1 | Active-low reset-in drive |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| cold_req | output | 1 | Cold-reset request after a failed warm reset |

## Verification
The hardest cases to reach are the window boundaries: a target level that arrives on the very last permitted tick, compared with one that arrives one tick too late, and a level change that falls between ticks and must not be seen. The bench builds a small configuration and sweeps the arrival tick across the entire window, from zero through one past its end, for power-on, power-off and the warm-reset watch. Between ticks it also holds the input at the target level on plain clock cycles to show that only ticks sample it.

// File: rtl/pmic_trigger_seq.sv
module pmic_trigger_seq #(
  parameter int unsigned WAIT_MS  = 350,
  parameter int unsigned PULSE_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       pgood,
  input  logic       key_rb,
  input  logic       ap_rst,
  output logic       key_n,
  output logic       resin_n,
  output logic       done,
  output logic       err,
  output logic       cold_req
);
  localparam int unsigned CMAX = (WAIT_MS > PULSE_MS) ? WAIT_MS : PULSE_MS;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_MS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_MS - 1);
  localparam logic [1:0] OP_ON = 2'd1, OP_OFF = 2'd2, OP_WARM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_PULSE, S_WATCH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          tgt;
  logic          key_q, resin_q, done_q, err_q, cold_q;

  wire want_on = (op == OP_ON);
  wire pwr_cmd = start && (op == OP_ON || op == OP_OFF);

  assign key_n    = key_q;
  assign resin_n  = resin_q;
  assign done     = done_q;
  assign err      = err_q;
  assign cold_req = cold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      tgt     <= 1'b0;
      key_q   <= 1'b1;
      resin_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cold_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cold_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (pwr_cmd) begin
            if (pgood == want_on) begin
              done_q <= 1'b1;
            end else if (!key_rb) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              st      <= S_HOLD;
              tgt     <= want_on;
              cnt     <= '0;
              key_q   <= 1'b0;
              resin_q <= want_on;
            end
          end else if (start && op == OP_WARM) begin
            st      <= S_PULSE;
            cnt     <= '0;
            resin_q <= 1'b0;
          end
        end
        S_HOLD: begin
          if (tick) begin
            if (pgood == tgt) begin
              st      <= S_IDLE;
              key_q   <= 1'b1;
              resin_q <= 1'b1;
              done_q  <= 1'b1;
            end else if (cnt == WAIT_LAST) begin
              st      <= S_IDLE;
              key_q   <= 1'b1;
              resin_q <= 1'b1;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_PULSE: begin
          if (tick) begin
            if (cnt == PULSE_LAST) begin
              st      <= S_WATCH;
              cnt     <= '0;
              resin_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_WATCH: begin
          if (tick) begin
            if (ap_rst) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else if (cnt == WAIT_LAST) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
              cold_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pmic_trigger_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic key_n,
  input logic resin_n,
  input logic done,
  input logic err,
  input logic cold_req
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_cold_with_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cold_req |-> (done && err));
  assert_pins_free_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (key_n && resin_n));
  assert_key_release_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_n) |-> done);
  assert_key_only_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_n) |-> $past(start));
endmodule

bind pmic_trigger_seq pmic_trigger_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_n(key_n), .resin_n(resin_n),
  .done(done), .err(err), .cold_req(cold_req)
);

// File: tb/pmic_trigger_seq_tb.sv
module pmic_trigger_seq_tb;
  localparam int W = 5;
  localparam int P = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0;
  logic pgood = 1'b0, key_rb = 1'b1, ap_rst = 1'b0;
  logic key_n, resin_n, done, err, cold_req;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pmic_trigger_seq #(.WAIT_MS(W), .PULSE_MS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .op(op),
    .pgood(pgood), .key_rb(key_rb), .ap_rst(ap_rst), .key_n(key_n),
    .resin_n(resin_n), .done(done), .err(err), .cold_req(cold_req)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {key_n,resin_n,done,err,cold}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {key_n, resin_n, done, err, cold_req};
  endfunction

  task automatic issue(input logic [1:0] o);
    @(negedge clk); start = 1'b1; op = o;
    @(posedge clk);
    @(negedge clk); start = 1'b0; op = 2'd0;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle_cycle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", outs(), 5'b11000);

    pgood = 1'b0; issue(2'd2);
    chk("R2 off already off", outs(), 5'b11100);
    idle_cycle(); chk("R10 done one cycle", outs(), 5'b11000);
    pgood = 1'b1; issue(2'd1);
    chk("R2 on already on", outs(), 5'b11100);
    idle_cycle();

    pgood = 1'b0; key_rb = 1'b0; issue(2'd1);
    chk("R3 readback low", outs(), 5'b11110);
    idle_cycle(); key_rb = 1'b1;

    issue(2'd0); chk("R9 op zero ignored", outs(), 5'b11000);

    for (int k = 0; k <= W; k++) begin
      pgood = 1'b0; issue(2'd1);
      chk("R4 on holds key", outs(), 5'b01000);
      for (int i = 0; i < k && i < W - 1; i++) begin
        tk(); chk("R4 waiting", outs(), 5'b01000);
      end
      if (k < W) begin
        @(negedge clk); pgood = 1'b1;
        idle_cycle(); chk("R4 no sample without tick", outs(), 5'b01000);
        tk(); chk("R4 on success", outs(), 5'b11100);
      end else begin
        tk(); chk("R6 on timeout", outs(), 5'b11110);
      end
      idle_cycle(); chk("R1 idle after on", outs(), 5'b11000);
    end

    for (int k = 0; k <= W; k++) begin
      pgood = 1'b1; issue(2'd2);
      chk("R5 off holds both", outs(), 5'b00000);
      for (int i = 0; i < k && i < W - 1; i++) begin
        tk(); chk("R5 waiting", outs(), 5'b00000);
      end
      if (k < W) begin
        @(negedge clk); pgood = 1'b0;
        tk(); chk("R5 off success", outs(), 5'b11100);
      end else begin
        tk(); chk("R6 off timeout", outs(), 5'b11110);
      end
      idle_cycle();
    end

    pgood = 1'b0; issue(2'd1);
    issue(2'd3); chk("R9 warm ignored while busy", outs(), 5'b01000);
    issue(2'd2); chk("R9 off ignored while busy", outs(), 5'b01000);
    @(negedge clk); pgood = 1'b1;
    tk(); chk("R9 outcome unchanged", outs(), 5'b11100);
    idle_cycle();

    for (int k = 0; k <= W; k++) begin
      ap_rst = 1'b0; issue(2'd3);
      chk("R7 resin low", outs(), 5'b10000);
      for (int i = 0; i < P - 1; i++) begin
        @(negedge clk); ap_rst = 1'b1;
        tk(); chk("R7 pulse width", outs(), 5'b10000);
        ap_rst = 1'b0;
      end
      tk(); chk("R7 resin released", outs(), 5'b11000);
      for (int i = 0; i < k && i < W - 1; i++) begin
        tk(); chk("R7 watching", outs(), 5'b11000);
      end
      if (k < W) begin
        @(negedge clk); ap_rst = 1'b1;
        tk(); chk("R7 warm ok", outs(), 5'b11100);
      end else begin
        tk(); chk("R8 cold request", outs(), 5'b11111);
      end
      ap_rst = 1'b0;
      idle_cycle(); chk("R10 flags drop", outs(), 5'b11000);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule